// File: doc/BRIEF.md
# Four-Lane Counter Block Generator

This block feeds a four-lane counter-mode cipher datapath. It holds one 128-bit base counter and emits four counter blocks per cycle on a 512-bit bus. Lane i carries the base with i+1 added to its last byte. The base is written from a 128-bit input. An advance strobe moves it forward by four, so the next group of four blocks follows on from the current one.

The block also closes the counter-mode loop. When a keystream word and a plaintext word arrive with a valid strobe, the XOR of the two appears on a registered 512-bit ciphertext output one cycle later, with its own valid flag. The block cipher rounds sit outside this block. Each lane's keystream is expected to come from encrypting that lane's counter block, with the same round key applied to all four lanes.

Only the last byte of a counter moves. The increment is a 32-bit addition on the top dword of the lane, and any carry out of that dword is thrown away. The last byte therefore wraps modulo 256 and never disturbs the lower 120 bits.

Top module: `ctr4_gen`

## Requirements
- R1: While rst_ni is low the base counter is zero, so lane i of ctr_o is zero except for its top byte, which is i+1. ct_valid_o and ct_o are zero.
- R2: Lane i of ctr_o occupies bits [128i+127:128i]. Its top byte, bits [128i+127:128i+120], equals the base's bits [127:120] plus i+1, modulo 256.
- R3: Bits [119:0] of every lane equal bits [119:0] of the base, including when the top byte wraps past 0xFF.
- R4: When load_i is high at a clock edge, init_ctr_i becomes the base, and ctr_o reflects it from that edge. load_i takes priority over adv_i.
- R5: When adv_i is high and load_i is low at a clock edge, the base's top byte grows by 4 modulo 256 and its lower 120 bits stay unchanged.
- R6: When both load_i and adv_i are low at a clock edge, ctr_o stays unchanged.
- R7: When data_valid_i is high at a clock edge, after that edge ct_o equals ks_i XOR pt_i and ct_valid_o is high.
- R8: When data_valid_i is low at a clock edge, after that edge ct_valid_o is low and ct_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write init_ctr_i into the base counter |
| init_ctr_i | input | 128 | Initial counter value |
| adv_i | input | 1 | Step the base on by one group of four |
| ctr_o | output | 512 | Four counter blocks, lane 0 in the low bits |
| data_valid_i | input | 1 | ks_i and pt_i hold valid data |
| ks_i | input | 512 | Keystream for four lanes |
| pt_i | input | 512 | Plaintext for four lanes |
| ct_valid_o | output | 1 | ct_o was updated at the last edge |
| ct_o | output | 512 | Registered ciphertext |

## Verification
The bench loads a base whose top byte is 0xFD, so the wrap happens inside one group. The expected lanes are FE, FF, 00 and 01. A design that let the carry ripple would corrupt byte 14 of lanes 2 and 3, and one that lost the carry inside the byte would give wrong top bytes.

Advancing from bytes near 0xFF checks the same wrap on the base register itself. Asserting load and advance together checks the priority: a design that got it wrong would emit the loaded value plus four.

Random traffic with valid gaps checks that the ciphertext is registered exactly once, and that it holds during gaps rather than tracking the inputs.

// File: rtl/ctr4_pkg.sv
package ctr4_pkg;
  localparam int unsigned BYTE_W = 8;

  // add amt to the top byte of a dword; carry out of the dword is dropped
  function automatic logic [31:0] top_byte_add(input logic [31:0] dw, input logic [7:0] amt);
    return dw + {amt, 24'h0};
  endfunction
endpackage

// File: rtl/ctr4_base_reg.sv
module ctr4_base_reg
  import ctr4_pkg::*;
#(
  parameter int unsigned LANE_W = 128,
  parameter int unsigned DW     = 32,
  parameter int unsigned STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LANE_W-1:0] init_i,
  input  logic              adv_i,
  output logic [LANE_W-1:0] base_o
);
  localparam int unsigned LO_W = LANE_W - DW;

  logic [LANE_W-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (load_i)     base_d = init_i;
    else if (adv_i) base_d = {top_byte_add(base_q[LANE_W-1 -: DW], BYTE_W'(STEP)), base_q[LO_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_d;
  end

  assign base_o = base_q;

  a_r5_adv_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> base_q[LANE_W-BYTE_W-1:0] == $past(base_q[LANE_W-BYTE_W-1:0]));
  a_r4_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_q == $past(init_i));
endmodule

// File: rtl/ctr4_lane_add.sv
module ctr4_lane_add
  import ctr4_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 128,
  parameter int unsigned DW     = 32
) (
  input  logic [LANE_W-1:0]       base_i,
  output logic [LANES*LANE_W-1:0] lanes_o
);
  localparam int unsigned LO_W = LANE_W - DW;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lanes_o[i*LANE_W +: LANE_W] =
      {top_byte_add(base_i[LANE_W-1 -: DW], BYTE_W'(i + 1)), base_i[LO_W-1:0]};
  end
endmodule

// File: rtl/ctr4_xor_stage.sv
module ctr4_xor_stage #(
  parameter int unsigned DATA_W = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] ks_i,
  input  logic [DATA_W-1:0] pt_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] ct_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ct_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) ct_o <= ks_i ^ pt_i;
    end
  end

  a_r7_ct_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (valid_o && ct_o == ($past(ks_i) ^ $past(pt_i))));
  a_r8_ct_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(ct_o)));
endmodule

// File: rtl/ctr4_gen.sv
module ctr4_gen #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 128,
  parameter int unsigned DW     = 32,
  localparam int unsigned BUS_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LANE_W-1:0] init_ctr_i,
  input  logic              adv_i,
  output logic [BUS_W-1:0]  ctr_o,
  input  logic              data_valid_i,
  input  logic [BUS_W-1:0]  ks_i,
  input  logic [BUS_W-1:0]  pt_i,
  output logic              ct_valid_o,
  output logic [BUS_W-1:0]  ct_o
);
  logic [LANE_W-1:0] base;

  ctr4_base_reg #(.LANE_W(LANE_W), .DW(DW), .STEP(LANES)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .init_i(init_ctr_i),
    .adv_i (adv_i),
    .base_o(base)
  );

  ctr4_lane_add #(.LANES(LANES), .LANE_W(LANE_W), .DW(DW)) u_lanes (
    .base_i (base),
    .lanes_o(ctr_o)
  );

  ctr4_xor_stage #(.DATA_W(BUS_W)) u_xor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(data_valid_i),
    .ks_i   (ks_i),
    .pt_i   (pt_i),
    .valid_o(ct_valid_o),
    .ct_o   (ct_o)
  );

  a_r5_adv_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> ctr_o[LANE_W-1 -: 8] == 8'($past(ctr_o[LANE_W-1 -: 8]) + 8'(LANES)));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(ctr_o));

  for (genvar i = 1; i < LANES; i++) begin : g_chk
    a_r2_lane_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      8'(ctr_o[i*LANE_W + LANE_W - 1 -: 8] - ctr_o[LANE_W-1 -: 8]) == 8'(i));
    a_r3_low_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctr_o[i*LANE_W +: LANE_W-8] == ctr_o[LANE_W-9:0]);
  end
endmodule

// File: tb/tb_ctr4_gen.sv
`timescale 1ns/1ps
module tb_ctr4_gen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0, adv = 1'b0, dv = 1'b0;
  logic [127:0] init = '0;
  logic [511:0] ks = '0, pt = '0;
  logic [511:0] ctr, ct;
  logic         ctv;

  int checks = 0;
  int fails  = 0;

  logic [127:0] base_m = '0;
  logic [511:0] ct_m   = '0;
  logic         ctv_m  = 1'b0;

  always #10 clk = ~clk;

  ctr4_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .init_ctr_i(init), .adv_i(adv),
    .ctr_o(ctr), .data_valid_i(dv), .ks_i(ks), .pt_i(pt),
    .ct_valid_o(ctv), .ct_o(ct)
  );

  function automatic logic [511:0] exp_lanes(input logic [127:0] b);
    logic [511:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i*128 +: 128] = {8'(b[127:120] + 8'(i + 1)), b[119:0]};
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " ctr"}, ctr, exp_lanes(base_m));
    chk({req, " ctv"}, {511'b0, ctv}, {511'b0, ctv_m});
    chk({req, " ct"}, ct, ct_m);
  endtask

  // drive at negedge, model the following posedge
  task automatic drive(input logic l, input logic [127:0] iv, input logic a,
                       input logic v, input logic [511:0] k, input logic [511:0] p);
    load = l; init = iv; adv = a; dv = v; ks = k; pt = p;
    if (l)      base_m = iv;
    else if (a) base_m[127:120] = base_m[127:120] + 8'd4;
    if (v) begin ct_m = k ^ p; ctv_m = 1'b1; end
    else ctv_m = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    chk("R1 lane3 top", {504'b0, ctr[511:504]}, {504'b0, 8'h04});
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: wrap inside one group
    drive(1'b1, 128'hFD00_1122_3344_5566_7788_99AA_BBCC_DDEE, 1'b0, 1'b0, '0, '0);
    check_all("R4 load");
    chk("R2 lane tops", {480'b0, ctr[511:504], ctr[383:376], ctr[255:248], ctr[127:120]},
        {480'b0, 32'h01_00_FF_FE});
    chk("R3 lane3 low", {392'b0, ctr[503:384]}, {392'b0, 120'h00_1122_3344_5566_7788_99AA_BBCC_DDEE});

    drive(1'b0, '0, 1'b1, 1'b0, '0, '0);
    check_all("R5 adv wrap");
    chk("R5 base top", {504'b0, ctr[127:120]}, {504'b0, 8'h02});

    drive(1'b0, '0, 1'b0, 1'b0, '0, '0);
    check_all("R6 hold");

    drive(1'b1, 128'h10FF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, '0, '0);
    check_all("R4 priority");
    chk("R4 priority top", {504'b0, ctr[127:120]}, {504'b0, 8'h11});

    drive(1'b1, 128'hFC00_0000_0000_0000_0000_0000_0000_00FF, 1'b0, 1'b0, '0, '0);
    drive(1'b0, '0, 1'b1, 1'b0, '0, '0);
    check_all("R3 adv wrap no carry");
    chk("R3 lane0", ctr[127:0] == 128'h0100_0000_0000_0000_0000_0000_0000_00FF ? 512'd1 : 512'd0, 512'd1);

    drive(1'b0, '0, 1'b0, 1'b1, {16{32'hA5A5_0F0F}}, {16{32'h5A5A_F0F0}});
    check_all("R7 xor");
    drive(1'b0, '0, 1'b0, 1'b0, rnd512(), rnd512());
    check_all("R8 hold");

    for (int n = 0; n < 300; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(r[0] & r[1] & r[2], {$urandom, $urandom, $urandom, $urandom}, r[1],
            r[3] | r[2], rnd512(), rnd512());
      check_all("R2 R5 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule